// File: doc/BRIEF.md
# Dual-rate CAN bit-timing generator

This block divides the system clock into time quanta and marks out each CAN FD bit. A bit is made of four segments: one synchronization quantum, a propagation segment, a first phase segment and a second phase segment. The block emits a one-cycle pulse for each quantum, a pulse when each bit begins, and a sample strobe where the first phase segment hands over to the second. It also reports which segment is running.

Two 32-bit timing words are supplied. One holds the nominal (arbitration) timing and the other holds the fast (data) timing. A rate-switch input chooses between them, and the choice is taken only when a bit begins. An edge detector outside the block reports recessive-to-dominant edges. While the bus is idle, such an edge hard-synchronizes the bit. While a frame is running, the edge moves the bit boundary by at most the synchronization jump width (SJW). Bit stuffing, framing, CRC and error counting belong to neighbouring blocks.

Top module: `can_bit_timer`

## Requirements
- R1: Each timing word holds every value as value minus one, in these fields: prescaler in bits 23:16, second phase in bits 10:8, first phase in bits 7:5, propagation in bits 4:2, and SJW in bits 1:0. Bits 15:11 and 31:24 are ignored.
- R2: While enabled, `tq_tick` pulses once every prescaler clocks.
- R3: Consecutive `bit_start` pulses are (1 + prop + phase1 + phase2) × prescaler clocks apart when no edge arrives. `seg` encodes sync = 0, propagation = 1, phase1 = 2 and phase2 = 3, and `seg` reads 0 whenever `bit_start` is high.
- R4: `sample_point` pulses (1 + prop + phase1) quanta after `bit_start`, in the cycle where `seg` changes from 2 to 3.
- R5: With `fast_sel` = 1 the data word times the bit, and with `fast_sel` = 0 the arbitration word does. The selection is captured only when a bit begins, so a change in mid-bit first affects the following bit.
- R6: An `rx_edge` pulse while `bus_idle` = 1 starts a new bit in the next cycle, abandoning the current one.
- R7: An `rx_edge` pulse in quantum q of the bit (1 ≤ q), falling in the propagation or first phase segment with `bus_idle` = 0, lengthens the first phase segment by min(q, SJW) quanta. This delays both the sample strobe and the next `bit_start`.
- R8: An `rx_edge` pulse in the second phase segment at quantum q of an N-quantum bit has r = N − q quanta remaining. If r ≤ SJW, a new bit begins in the next cycle. Otherwise the second phase segment is shortened by SJW quanta.
- R9: At most one soft resynchronization takes effect per bit. An edge during the sync quantum has no effect.
- R10: The effective SJW is min(SJW field + 1, phase2).
- R11: One cycle after `enable` is low, every output is 0 and all counters are cleared. One cycle after `enable` rises, `bit_start` pulses.
- R12: The timing words must not change while `enable` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transfer enable; low clears and silences the block |
| fast_sel | input | 1 | Rate switch: 1 selects the data timing word |
| bus_idle | input | 1 | High while the bus is idle, so edges hard-synchronize |
| rx_edge | input | 1 | One-cycle pulse on a recessive-to-dominant edge |
| arb_timing | input | 32 | Arbitration-phase timing word |
| data_timing | input | 32 | Data-phase timing word |
| tq_tick | output | 1 | Pulse at the end of each time quantum |
| sample_point | output | 1 | Pulse at the sample position |
| bit_start | output | 1 | Pulse at the first cycle of each bit |
| seg | output | 2 | Current segment code |

## Verification
The assertions check on every cycle the relations that hold no matter how long a bit is:
- outputs go silent after `enable` drops;
- `bit_start` only occurs in the sync segment, and it never coincides with the sample strobe;
- the strobe coincides with entry into phase 2;
- the timing words are frozen while enabled.

The bench sweeps prescaler and segment lengths arithmetically to check the spacing of quanta, strobes and bits. It places edges at chosen quanta to check the lengthening, shortening, SJW clamp, single-resync rule and hard synchronization. It also checks the per-bit latching of the rate switch. These are matters of cycle counts that no single-cycle property can show.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int WORD_W    = 32;
    localparam int BRP_W     = 8;
    localparam int FLD_W     = 3;
    localparam int SJW_FLD_W = 2;
    localparam int SEG_W     = FLD_W + 1;
    localparam int LEN_W     = SEG_W + 1;
    localparam int BRP_LSB   = 16;
    localparam int PH2_LSB   = 8;
    localparam int PH1_LSB   = 5;
    localparam int PROP_LSB  = 2;
    localparam int SJW_LSB   = 0;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [BRP_W-1:0] brp_m1;
        logic [SEG_W-1:0] prop;
        logic [SEG_W-1:0] ph1;
        logic [SEG_W-1:0] ph2;
        logic [SEG_W-1:0] sjw;
    } timing_t;
endpackage

// File: rtl/can_bt_decode.sv
module can_bt_decode
    import can_bt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output timing_t           tm
);
    logic [SEG_W-1:0] sjw_raw;
    logic             unused_rsvd;

    assign unused_rsvd = ^{word[WORD_W-1:BRP_LSB+BRP_W], word[BRP_LSB-1:PH2_LSB+FLD_W]};

    always_comb begin
        tm.brp_m1 = word[BRP_LSB +: BRP_W];
        tm.prop   = SEG_W'(word[PROP_LSB +: FLD_W]) + SEG_W'(1);
        tm.ph1    = SEG_W'(word[PH1_LSB +: FLD_W]) + SEG_W'(1);
        tm.ph2    = SEG_W'(word[PH2_LSB +: FLD_W]) + SEG_W'(1);
        sjw_raw   = SEG_W'(word[SJW_LSB +: SJW_FLD_W]) + SEG_W'(1);
        // jump width may never exceed the second phase segment
        tm.sjw    = (sjw_raw > tm.ph2) ? tm.ph2 : sjw_raw;
    end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp_m1,
    output logic             end_tq
);
    logic [BRP_W-1:0] pc_d, pc_q;

    assign end_tq = run && (pc_q >= brp_m1);

    always_comb begin
        if (!run || restart || end_tq) begin
            pc_d = '0;
        end else begin
            pc_d = pc_q + BRP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fast_sel,
    input  logic              bus_idle,
    input  logic              rx_edge,
    input  logic [WORD_W-1:0] arb_timing,
    input  logic [WORD_W-1:0] data_timing,
    output logic              tq_tick,
    output logic              sample_point,
    output logic              bit_start,
    output logic [1:0]        seg
);
    localparam int NUM_RATES = 2;

    typedef struct packed {
        logic             run;
        seg_e             seg;
        logic [LEN_W-1:0] qc;
        timing_t          act;
        logic [SEG_W-1:0] ext;
        logic [SEG_W-1:0] shr;
        logic             done;
        logic             tick;
        logic             samp;
        logic             bstart;
    } state_t;

    state_t            st_d, st_q;
    timing_t           tm [NUM_RATES];
    logic [WORD_W-1:0] words [NUM_RATES];
    timing_t           cur;
    logic              end_tq, restart, new_bit;
    logic [LEN_W-1:0]  seg_len, elapsed, remain, sjw_l;

    assign words[0] = arb_timing;
    assign words[1] = data_timing;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_dec
        can_bt_decode u_dec (.word(words[g]), .tm(tm[g]));
    end

    can_bt_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .restart (restart),
        .brp_m1  (st_q.act.brp_m1),
        .end_tq  (end_tq)
    );

    always_comb begin
        st_d        = st_q;
        st_d.tick   = 1'b0;
        st_d.samp   = 1'b0;
        st_d.bstart = 1'b0;
        new_bit     = 1'b0;
        restart     = 1'b0;
        cur         = fast_sel ? tm[1] : tm[0];

        case (st_q.seg)
            SEG_SYNC: seg_len = LEN_W'(1);
            SEG_PROP: seg_len = LEN_W'(st_q.act.prop);
            SEG_PH1:  seg_len = LEN_W'(st_q.act.ph1) + LEN_W'(st_q.ext);
            default:  seg_len = LEN_W'(st_q.act.ph2) - LEN_W'(st_q.shr);
        endcase
        // quanta since the sync quantum, counting the one in progress
        elapsed = ((st_q.seg == SEG_PH1) ? LEN_W'(st_q.act.prop) : '0) + st_q.qc + LEN_W'(1);
        remain  = LEN_W'(st_q.act.ph2) - st_q.qc;
        sjw_l   = LEN_W'(st_q.act.sjw);

        if (!enable) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            new_bit  = 1'b1;
        end else begin
            st_d.tick = end_tq;
            if (end_tq) begin
                if (st_q.qc + LEN_W'(1) >= seg_len) begin
                    st_d.qc = '0;
                    case (st_q.seg)
                        SEG_SYNC: st_d.seg = SEG_PROP;
                        SEG_PROP: st_d.seg = SEG_PH1;
                        SEG_PH1: begin
                            st_d.seg  = SEG_PH2;
                            st_d.samp = 1'b1;
                        end
                        default: new_bit = 1'b1;
                    endcase
                end else begin
                    st_d.qc = st_q.qc + LEN_W'(1);
                end
            end
            if (rx_edge) begin
                if (bus_idle) begin
                    new_bit = 1'b1;
                end else if (!st_q.done && (st_q.seg != SEG_SYNC)) begin
                    st_d.done = 1'b1;
                    if (st_q.seg == SEG_PH2) begin
                        if (remain <= sjw_l) begin
                            new_bit = 1'b1;
                        end else begin
                            st_d.shr = st_q.act.sjw;
                        end
                    end else begin
                        st_d.ext = (elapsed < sjw_l) ? SEG_W'(elapsed) : st_q.act.sjw;
                    end
                end
            end
        end

        if (new_bit) begin
            st_d.seg    = SEG_SYNC;
            st_d.qc     = '0;
            st_d.act    = cur;
            st_d.ext    = '0;
            st_d.shr    = '0;
            st_d.done   = 1'b0;
            st_d.samp   = 1'b0;
            st_d.bstart = 1'b1;
            restart     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tq_tick      = st_q.tick;
    assign sample_point = st_q.samp;
    assign bit_start    = st_q.bstart;
    assign seg          = st_q.seg;
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [31:0] arb_timing,
    input logic [31:0] data_timing,
    input logic        tq_tick,
    input logic        sample_point,
    input logic        bit_start,
    input logic [1:0]  seg
);
    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tq_tick && !sample_point && !bit_start && seg == 2'd0));

    assert_start_in_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> seg == 2'd0);

    assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_start, sample_point}));

    assert_sample_enters_ph2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_point |-> (seg == 2'd3 && $past(seg) == 2'd2));

    assert_words_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(arb_timing) && $stable(data_timing)));
endmodule

bind can_bit_timer can_bt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .arb_timing   (arb_timing),
    .data_timing  (data_timing),
    .tq_tick      (tq_tick),
    .sample_point (sample_point),
    .bit_start    (bit_start),
    .seg          (seg)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable, fast_sel, bus_idle, rx_edge;
    logic [31:0] arb_timing, data_timing;
    logic        tq_tick, sample_point, bit_start;
    logic [1:0]  seg;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
        .bus_idle(bus_idle), .rx_edge(rx_edge), .arb_timing(arb_timing),
        .data_timing(data_timing), .tq_tick(tq_tick), .sample_point(sample_point),
        .bit_start(bit_start), .seg(seg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int brp, input int prop, input int ph1,
                                         input int ph2, input int sjw);
        return (32'(brp - 1) << 16) | (32'(ph2 - 1) << 8) | (32'(ph1 - 1) << 5)
             | (32'(prop - 1) << 2) | 32'(sjw - 1);
    endfunction

    // disable, load new words, enable; returns at the first bit_start negedge
    task automatic reload(input logic [31:0] aw, input logic [31:0] dw);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        arb_timing  = aw;
        data_timing = dw;
        enable = 1'b1;
        @(negedge clk);
        chk(bit_start == 1'b1, "R11 bit_start after enable", int'(bit_start), 1);
    endtask

    // starts at a bit_start negedge (cycle 0), ends at the next one
    task automatic run_bit(input int e1, input int e2, input bit idle, input int sel_at,
                           input bit sel_v, output int so, output int bl, output int ssp);
        int c;
        c = 0; so = -1; bl = -1; ssp = -1;
        bus_idle = idle;
        forever begin
            rx_edge = (c == e1) || (c == e2);
            if (c == sel_at) fast_sel = sel_v;
            @(negedge clk);
            c++;
            rx_edge = 1'b0;
            if (sample_point && so < 0) begin
                so  = c;
                ssp = int'(seg);
            end
            if (bit_start || c > 5000) begin
                bl = c;
                break;
            end
        end
        bus_idle = 1'b0;
    endtask

    task automatic tick_period(output int p);
        int g;
        g = 0;
        do begin @(negedge clk); g++; end while (!tq_tick && g < 5000);
        p = 0;
        do begin @(negedge clk); p++; end while (!tq_tick && p < 5000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int so, bl, ssp, p;
        int props [3] = '{1, 3, 8};
        int ph1s [2]  = '{1, 4};
        int ph2s [2]  = '{2, 8};
        enable = 0; fast_sel = 0; bus_idle = 0; rx_edge = 0;
        arb_timing = word(2, 2, 3, 3, 2);
        data_timing = word(1, 1, 1, 2, 1);
        repeat (3) @(negedge clk);
        chk({tq_tick, sample_point, bit_start, seg} == 5'd0, "R11 reset state",
            int'({tq_tick, sample_point, bit_start, seg}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({tq_tick, sample_point, bit_start, seg} == 5'd0, "R11 idle while disabled",
            int'({tq_tick, sample_point, bit_start, seg}), 0);

        // brp 2, prop 2, ph1 3, ph2 3, sjw 2: N = 9 quanta, 18 clocks, sample at 12
        enable = 1'b1;
        @(negedge clk);
        chk(bit_start == 1'b1, "R11 first bit_start", int'(bit_start), 1);
        chk(seg == 2'd0, "R3 seg at bit_start", int'(seg), 0);
        run_bit(-1, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 18, "R3 plain bit length", bl, 18);
        chk(so == 12, "R4 plain sample offset", so, 12);
        chk(ssp == 3, "R4 seg at sample", ssp, 3);
        run_bit(2, -1, 0, -1, 0, so, bl, ssp);
        chk(so == 14, "R7 late edge q1 sample", so, 14);
        chk(bl == 20, "R7 late edge q1 length", bl, 20);
        run_bit(8, -1, 0, -1, 0, so, bl, ssp);
        chk(so == 16, "R7 late edge capped sample", so, 16);
        chk(bl == 22, "R7 late edge capped length", bl, 22);
        run_bit(12, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 14, "R8 early edge shorten", bl, 14);
        chk(so == 12, "R8 early edge keeps sample", so, 12);
        run_bit(14, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 15, "R8 early edge immediate", bl, 15);
        run_bit(0, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 18, "R9 edge in sync ignored", bl, 18);
        run_bit(2, 6, 0, -1, 0, so, bl, ssp);
        chk(bl == 20, "R9 second edge ignored", bl, 20);
        chk(so == 14, "R9 second edge sample", so, 14);
        run_bit(8, -1, 1, -1, 0, so, bl, ssp);
        chk(bl == 9, "R6 hard sync restarts bit", bl, 9);
        chk(so == -1, "R6 no sample before hard sync", so, -1);
        run_bit(-1, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 18, "R6 bit after hard sync", bl, 18);

        // SJW clamp: field 4 but ph2 2; brp 2 prop 1 ph1 4 ph2 2, edge in q4
        reload(word(2, 1, 4, 2, 4), word(1, 1, 1, 2, 1));
        run_bit(8, -1, 0, -1, 0, so, bl, ssp);
        chk(so == 16, "R10 clamped sjw sample", so, 16);
        chk(bl == 20, "R10 clamped sjw length", bl, 20);
        reload(word(2, 1, 4, 2, 1), word(1, 1, 1, 2, 1));
        run_bit(8, -1, 0, -1, 0, so, bl, ssp);
        chk(so == 14, "R1 sjw field decode", so, 14);
        chk(bl == 18, "R1 sjw field length", bl, 18);

        // rate switch: arb 18 clocks, data 5 clocks per bit
        reload(word(2, 2, 3, 3, 2), word(1, 1, 1, 2, 1));
        run_bit(-1, -1, 0, 3, 1, so, bl, ssp);
        chk(bl == 18, "R5 mid-bit switch deferred", bl, 18);
        run_bit(-1, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 5, "R5 data rate bit", bl, 5);
        chk(so == 3, "R5 data rate sample", so, 3);
        run_bit(-1, -1, 0, 1, 0, so, bl, ssp);
        chk(bl == 5, "R5 switch back deferred", bl, 5);
        run_bit(-1, -1, 0, -1, 0, so, bl, ssp);
        chk(bl == 18, "R5 arbitration rate again", bl, 18);

        // sweep of prescaler and segment lengths
        for (int b = 1; b <= 3; b++) begin
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < 2; j++) begin
                    for (int k = 0; k < 2; k++) begin
                        reload(word(b, props[i], ph1s[j], ph2s[k], 1), word(1, 1, 1, 2, 1));
                        run_bit(-1, -1, 0, -1, 0, so, bl, ssp);
                        chk(bl == b * (1 + props[i] + ph1s[j] + ph2s[k]), "R3 sweep length",
                            bl, b * (1 + props[i] + ph1s[j] + ph2s[k]));
                        chk(so == b * (1 + props[i] + ph1s[j]), "R4 sweep sample",
                            so, b * (1 + props[i] + ph1s[j]));
                        chk(ssp == 3, "R4 sweep seg", ssp, 3);
                        tick_period(p);
                        chk(p == b, "R2 quantum period", p, b);
                    end
                end
            end
        end

        // disabling silences outputs, edges while off are ignored
        enable = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 6; c++) begin
            rx_edge = c[0];
            @(negedge clk);
            chk({tq_tick, sample_point, bit_start, seg} == 5'd0, "R11 silent while disabled",
                int'({tq_tick, sample_point, bit_start, seg}), 0);
        end
        rx_edge = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule